// File: doc/BRIEF.md
# Advanced-Load Address Check Table

This block lets a statically scheduled pipeline hoist a load above stores that might write the same bytes. When such an early (advanced) load issues, it records its byte range in the table under its destination register number. Every store that follows sends its own byte range to the table. The table compares that range against all entries in parallel and drops each entry that overlaps it.

When the program reaches the load's original position, it issues a check for the destination register. The check passes only if a live entry for that register is still present. A failed check means the register was overwritten by an aliasing store, was evicted, or was never recorded, and the caller must run its recovery path.

The table holds 16 entries by default. Each entry has a valid bit, a register number, a 32-bit address and a 2-bit size code. If a register is inserted again, its existing entry is reused. When the table is full, a round-robin pointer picks the entry to overwrite. A clear input empties the whole table in one cycle. The result of a check is registered and appears one cycle after the request.

Top module: `lct_table`

## Requirements
- R1: After reset, no entry is live, so a check of any register reports failure.
- R2: `chk_done` is high in exactly the cycle after a cycle with `chk_valid` high, and low after any cycle without a check request.
- R3: An inserted register with no intervening aliasing store checks as passing. A passing check does not remove the entry, so a repeated check also passes.
- R4: A check of a register that was never inserted reports failure.
- R5: A store whose byte range overlaps an entry's byte range kills that entry, so a later check fails. The size code gives the length in bytes: 0 = 1, 1 = 2, 2 = 4, 3 = 8. A range covers the bytes from addr to addr+len-1.
- R6: A store whose range only touches an entry's range at the boundary (it ends just below the entry's range or starts just after it) leaves the entry live.
- R7: A single store kills every overlapping entry in the same cycle and leaves non-overlapping entries live.
- R8: Inserting a register that already has a live entry overwrites that entry in place. Afterwards only the new range is checked against stores.
- R9: When all entries are live and a new register is inserted, the entry at the round-robin pointer is evicted and the pointer advances by one. The pointer starts at slot 0 after reset or clear. Free slots are filled lowest index first. Re-inserting a register that is already present evicts nothing.
- R10: When an insert and an overlapping store arrive in the same cycle, the new entry survives, while older overlapping entries are killed.
- R11: `clear` kills all entries in one cycle and takes priority over an insert in the same cycle.
- R12: A check sees the table as it stood before any insert, store or clear in the same cycle.
- R13: No two live entries ever hold the same register number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Kill all entries and reset the victim pointer |
| ins_valid | input | 1 | Advanced-load insert request |
| ins_reg | input | 7 | Destination register of the advanced load |
| ins_addr | input | 32 | Byte address of the load |
| ins_size | input | 2 | Load size code |
| st_valid | input | 1 | Store probe request |
| st_addr | input | 32 | Byte address of the store |
| st_size | input | 2 | Store size code |
| chk_valid | input | 1 | Check request |
| chk_reg | input | 7 | Register being checked |
| chk_done | output | 1 | Check result valid (one cycle after request) |
| chk_ok | output | 1 | Check passed; low means recovery is needed |

## Verification
The only outputs are the check results, so an internal fault shows up on the next check of the affected register, one cycle after that request.

Some faults are silent until a particular check is made:
- An entry that is wrongly dropped appears as a failing check on an unaliased load.
- An entry that is wrongly kept (a missed overlap, a bad boundary compare, or a lost clear) appears as a passing check that should have failed.
- A wrong victim pointer or allocation order appears only after the table fills, as the wrong register failing.

The directed scenarios therefore check the boundary-adjacent ranges, same-cycle collisions and the eviction order register by register.

// File: rtl/lct_pkg.sv
package lct_pkg;
  localparam int SZW = 2;

  typedef enum logic [SZW-1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } acc_size_e;
endpackage

// File: rtl/lct_overlap.sv
module lct_overlap #(
  parameter int AW  = 32,
  parameter int SZW = lct_pkg::SZW
) (
  input  logic [AW-1:0]  a_base,
  input  logic [SZW-1:0] a_size,
  input  logic [AW-1:0]  b_base,
  input  logic [SZW-1:0] b_size,
  output logic           hit
);
  localparam int EW = AW + 1;
  logic [EW-1:0] a_lo, a_hi, b_lo, b_hi;

  always_comb begin
    a_lo = {1'b0, a_base};
    b_lo = {1'b0, b_base};
    a_hi = a_lo + (EW'(1) << a_size);
    b_hi = b_lo + (EW'(1) << b_size);
    hit  = (a_lo < b_hi) && (b_lo < a_hi);
  end
endmodule

// File: rtl/lct_alloc.sv
module lct_alloc #(
  parameter int N  = 16,
  parameter int RW = 7,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          ins_valid,
  input  logic [RW-1:0] ins_reg,
  input  logic [N-1:0]  vld,
  input  logic [RW-1:0] tags [N],
  output logic [IW-1:0] slot
);
  logic [N-1:0]  same_reg;
  logic          any_same, any_free;
  logic [IW-1:0] same_idx, free_idx;
  logic [IW-1:0] rr_q;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign same_reg[g] = vld[g] && (tags[g] == ins_reg);
  end

  always_comb begin
    any_same = 1'b0;
    any_free = 1'b0;
    same_idx = '0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (same_reg[i]) begin
        any_same = 1'b1;
        same_idx = IW'(i);
      end
      if (!vld[i]) begin
        any_free = 1'b1;
        free_idx = IW'(i);
      end
    end
    if (any_same)      slot = same_idx;
    else if (any_free) slot = free_idx;
    else               slot = rr_q;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      rr_q <= '0;
    end else if (ins_valid && !any_same && !any_free) begin
      rr_q <= (rr_q == IW'(N - 1)) ? '0 : rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/lct_table.sv
module lct_table #(
  parameter int N   = 16,
  parameter int AW  = 32,
  parameter int RW  = 7,
  localparam int SZW = lct_pkg::SZW,
  localparam int IW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clear,
  input  logic           ins_valid,
  input  logic [RW-1:0]  ins_reg,
  input  logic [AW-1:0]  ins_addr,
  input  logic [SZW-1:0] ins_size,
  input  logic           st_valid,
  input  logic [AW-1:0]  st_addr,
  input  logic [SZW-1:0] st_size,
  input  logic           chk_valid,
  input  logic [RW-1:0]  chk_reg,
  output logic           chk_done,
  output logic           chk_ok
);
  logic [N-1:0]   vld_q;
  logic [RW-1:0]  tag_q  [N];
  logic [AW-1:0]  addr_q [N];
  logic [SZW-1:0] size_q [N];
  logic [N-1:0]   st_hit;
  logic [N-1:0]   chk_hit;
  logic [IW-1:0]  slot;
  logic           done_q, ok_q;

  for (genvar g = 0; g < N; g++) begin : g_ent
    lct_overlap #(.AW(AW), .SZW(SZW)) u_ovl (
      .a_base(addr_q[g]),
      .a_size(size_q[g]),
      .b_base(st_addr),
      .b_size(st_size),
      .hit   (st_hit[g])
    );
    assign chk_hit[g] = vld_q[g] && (tag_q[g] == chk_reg);
  end

  lct_alloc #(.N(N), .RW(RW)) u_alloc (
    .clk      (clk),
    .rst      (rst),
    .clear    (clear),
    .ins_valid(ins_valid),
    .ins_reg  (ins_reg),
    .vld      (vld_q),
    .tags     (tag_q),
    .slot     (slot)
  );

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      vld_q <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (st_valid && st_hit[i]) vld_q[i] <= 1'b0;
      end
      if (ins_valid) vld_q[slot] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ins_valid && !clear && !rst) begin
      tag_q[slot]  <= ins_reg;
      addr_q[slot] <= ins_addr;
      size_q[slot] <= ins_size;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      done_q <= chk_valid;
      ok_q   <= chk_valid && (|chk_hit);
    end
  end

  assign chk_done = done_q;
  assign chk_ok   = ok_q;
endmodule

// File: rtl/lct_table_chk.sv
module lct_table_chk #(
  parameter int N  = 16,
  parameter int RW = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          clear,
  input logic          ins_valid,
  input logic          st_valid,
  input logic          chk_valid,
  input logic          chk_done,
  input logic          chk_ok,
  input logic [N-1:0]  vld_q,
  input logic [RW-1:0] tag_q [N]
);
  logic dup;
  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < N; i++)
      for (int j = i + 1; j < N; j++)
        if (vld_q[i] && vld_q[j] && tag_q[i] == tag_q[j]) dup = 1'b1;
  end

  AST_DONE_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst) chk_valid |=> chk_done); // R2
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (rst) !chk_valid |=> !chk_done); // R2
  AST_OK_ONLY_WITH_DONE: assert property (@(posedge clk) disable iff (rst) chk_ok |-> chk_done); // R2
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst) clear |=> (vld_q == '0)); // R11
  AST_INSERT_LIVE: assert property (@(posedge clk) disable iff (rst) (ins_valid && !clear) |=> (vld_q != '0)); // R10
  AST_STORE_NO_GROWTH: assert property (@(posedge clk) disable iff (rst)
    (st_valid && !ins_valid) |=> ($countones(vld_q) <= $countones($past(vld_q)))); // R7
  AST_UNIQUE_REG: assert property (@(posedge clk) disable iff (rst) !dup); // R13
endmodule

bind lct_table lct_table_chk #(.N(N), .RW(RW)) u_lct_table_chk (
  .clk      (clk),
  .rst      (rst),
  .clear    (clear),
  .ins_valid(ins_valid),
  .st_valid (st_valid),
  .chk_valid(chk_valid),
  .chk_done (chk_done),
  .chk_ok   (chk_ok),
  .vld_q    (vld_q),
  .tag_q    (tag_q)
);

// File: tb/lct_table_test.sv
module lct_table_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clear = 1'b0;
  logic        ins_valid = 1'b0;
  logic [6:0]  ins_reg = '0;
  logic [31:0] ins_addr = '0;
  logic [1:0]  ins_size = '0;
  logic        st_valid = 1'b0;
  logic [31:0] st_addr = '0;
  logic [1:0]  st_size = '0;
  logic        chk_valid = 1'b0;
  logic [6:0]  chk_reg = '0;
  logic        chk_done, chk_ok;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lct_table uut (
    .clk(clk), .rst(rst), .clear(clear),
    .ins_valid(ins_valid), .ins_reg(ins_reg), .ins_addr(ins_addr), .ins_size(ins_size),
    .st_valid(st_valid), .st_addr(st_addr), .st_size(st_size),
    .chk_valid(chk_valid), .chk_reg(chk_reg),
    .chk_done(chk_done), .chk_ok(chk_ok)
  );

  // Drive one cycle of requests at a negedge, return at the next negedge idle.
  task automatic step(input logic iv, input logic [6:0] ir, input logic [31:0] ia, input logic [1:0] is,
                      input logic sv, input logic [31:0] sa, input logic [1:0] ss,
                      input logic cv, input logic [6:0] cr, input logic cl);
    ins_valid = iv; ins_reg = ir; ins_addr = ia; ins_size = is;
    st_valid = sv; st_addr = sa; st_size = ss;
    chk_valid = cv; chk_reg = cr; clear = cl;
    @(negedge clk);
    ins_valid = 1'b0; st_valid = 1'b0; chk_valid = 1'b0; clear = 1'b0;
  endtask

  task automatic ins(input logic [6:0] r, input logic [31:0] a, input logic [1:0] s);
    step(1'b1, r, a, s, 1'b0, '0, '0, 1'b0, '0, 1'b0);
  endtask

  task automatic store(input logic [31:0] a, input logic [1:0] s);
    step(1'b0, '0, '0, '0, 1'b1, a, s, 1'b0, '0, 1'b0);
  endtask

  task automatic do_clear();
    step(1'b0, '0, '0, '0, 1'b0, '0, '0, 1'b0, '0, 1'b1);
  endtask

  task automatic expect_res(input logic exp_ok, input string req);
    checks++;
    if (chk_done !== 1'b1 || chk_ok !== exp_ok) begin
      errors++;
      $display("FAIL %s: done=%b ok=%b expected done=1 ok=%b", req, chk_done, chk_ok, exp_ok);
    end
  endtask

  task automatic check_reg(input logic [6:0] r, input logic exp_ok, input string req);
    step(1'b0, '0, '0, '0, 1'b0, '0, '0, 1'b1, r, 1'b0);
    expect_res(exp_ok, req);
  endtask

  task automatic t_reset();
    check_reg(7'd5, 1'b0, "R1");
    step(1'b0, '0, '0, '0, 1'b0, '0, '0, 1'b0, '0, 1'b0);
    checks++;
    if (chk_done !== 1'b0) begin
      errors++;
      $display("FAIL R2: done=%b expected 0", chk_done);
    end
  endtask

  task automatic t_insert_check();
    ins(7'd3, 32'h100, 2'd2);
    check_reg(7'd3, 1'b1, "R3");
    check_reg(7'd3, 1'b1, "R3");
    check_reg(7'd9, 1'b0, "R4");
  endtask

  task automatic t_overlap();
    ins(7'd4, 32'h200, 2'd3);
    store(32'h206, 2'd0);
    check_reg(7'd4, 1'b0, "R5");
    ins(7'd4, 32'h200, 2'd3);
    store(32'h1FE, 2'd1);
    check_reg(7'd4, 1'b1, "R6");
    store(32'h208, 2'd2);
    check_reg(7'd4, 1'b1, "R6");
    store(32'h1FF, 2'd1);
    check_reg(7'd4, 1'b0, "R5");
  endtask

  task automatic t_multi();
    do_clear();
    ins(7'd10, 32'h300, 2'd2);
    ins(7'd11, 32'h302, 2'd1);
    ins(7'd12, 32'h400, 2'd2);
    store(32'h300, 2'd3);
    check_reg(7'd10, 1'b0, "R7");
    check_reg(7'd11, 1'b0, "R7");
    check_reg(7'd12, 1'b1, "R7");
  endtask

  task automatic t_replace();
    ins(7'd20, 32'h500, 2'd2);
    ins(7'd20, 32'h600, 2'd2);
    store(32'h500, 2'd2);
    check_reg(7'd20, 1'b1, "R8");
    store(32'h600, 2'd0);
    check_reg(7'd20, 1'b0, "R8");
  endtask

  task automatic t_full();
    do_clear();
    for (int i = 0; i < N; i++) ins(7'(32 + i), 32'h1000 + 32'(i * 16), 2'd2);
    ins(7'd48, 32'h2000, 2'd2);
    ins(7'd49, 32'h2010, 2'd2);
    ins(7'd35, 32'h3000, 2'd2);
    check_reg(7'd32, 1'b0, "R9");
    check_reg(7'd33, 1'b0, "R9");
    check_reg(7'd34, 1'b1, "R9");
    check_reg(7'd35, 1'b1, "R9");
    check_reg(7'd48, 1'b1, "R9");
    check_reg(7'd49, 1'b1, "R9");
  endtask

  task automatic t_same_cycle();
    do_clear();
    ins(7'd50, 32'h700, 2'd2);
    step(1'b1, 7'd51, 32'h700, 2'd2, 1'b1, 32'h700, 2'd2, 1'b0, '0, 1'b0);
    check_reg(7'd50, 1'b0, "R10");
    check_reg(7'd51, 1'b1, "R10");
  endtask

  task automatic t_check_order();
    ins(7'd52, 32'h800, 2'd2);
    step(1'b0, '0, '0, '0, 1'b1, 32'h800, 2'd2, 1'b1, 7'd52, 1'b0);
    expect_res(1'b1, "R12");
    check_reg(7'd52, 1'b0, "R12");
  endtask

  task automatic t_clear();
    ins(7'd53, 32'h900, 2'd2);
    ins(7'd54, 32'hA00, 2'd2);
    step(1'b1, 7'd55, 32'hB00, 2'd2, 1'b0, '0, '0, 1'b0, '0, 1'b1);
    check_reg(7'd53, 1'b0, "R11");
    check_reg(7'd54, 1'b0, "R11");
    check_reg(7'd55, 1'b0, "R11");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_insert_check();
    t_overlap();
    t_multi();
    t_replace();
    t_full();
    t_same_cycle();
    t_check_order();
    t_clear();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule